// File: doc/BRIEF.md
# Serial Port Register Bank with FIFO Status Flags

This block is the register bank of a FIFO-based serial controller. A small synchronous bus with a byte offset reaches it. It holds the configuration bytes for framing mode, bit rate, control and port pins, and a 16-bit FIFO control word. It also keeps five sticky status flags. Software clears a flag by writing a zero to its bit, and a one written to a bit leaves that flag as it is.

The data path sits outside the block. A write to the transmit data offset produces a one-cycle byte strobe towards the shifter. A read of the receive data offset returns the byte at the head of the external receive FIFO and pops it. The FIFO reports its fill level and two events: the trigger level was reached, and the line went idle with data pending. A line break detector reports breaks on a separate input. From all of this state the block drives the transmit, receive and break interrupt lines.

Top module: `sercfg_regs`

## Requirements
- R1: After reset the framing mode reads 0x00, the bit rate reads 0xFF, control reads 0x20, the port and FIFO control registers read 0, the status register reads 0x60, all three interrupt lines are low and the receive trigger is 1.
- R2: Writes are masked bit by bit. Mode (offset 0x00) keeps wdata & 0x7B, control (0x08) keeps wdata & 0xFA, port (0x20) keeps wdata & 0xF3, and bit rate (0x04) keeps wdata[7:0]. Each register reads back at its offset.
- R3: Status (offset 0x10) places transmit-end on bit 6, transmit-empty on bit 5, break on bit 4, receive-trigger on bit 1 and data-ready on bit 0, and reads 0 in every other bit. A status write clears each of these flags whose bit is written 0 and leaves each flag whose bit is written 1.
- R4: A status write with bit 1 or bit 0 at 0 drives the receive interrupt low in the next cycle.
- R5: A control write with bit 5 at 0 sets transmit-end. The transmit interrupt takes the value of bit 7 of each control write. A control write with bit 6 at 0 drives the receive interrupt low.
- R6: A write to the transmit data offset (0x0C) raises tx_valid for exactly the next cycle with tx_byte equal to wdata[7:0], and clears transmit-empty. A read of 0x0C returns 0.
- R7: A status read while control bit 5 is 1 returns the current flags. It then sets transmit-end and transmit-empty in the next cycle. With control bit 5 at 0 a status read changes nothing.
- R8: A FIFO control write (offset 0x18) stores the whole 16-bit word. If bit 1 is 1, the write pulses fifo_flush for the next cycle and clears receive-trigger. Bits 7:6 select a receive trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14.
- R9: Offset 0x1C reads the FIFO fill level and offset 0x24 reads 0. A read of any unmapped offset returns 0, and a write to one changes no register.
- R10: A read of receive data (0x14) with a non-zero fill level returns the head byte and asserts rx_pop in that cycle. If the fill level minus one is below the trigger, the read also clears receive-trigger. With a fill level of 0 the read returns 0 and does not pop.
- R11: The trigger event sets receive-trigger and the idle event sets data-ready. Either event raises the receive interrupt when control bit 6 is 1. A clearing write in the same cycle takes priority on the interrupt line.
- R12: A break event sets the break flag. The break interrupt is high while the break flag and control bit 6 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational during a read |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| fifo_level | input | 5 | Receive FIFO fill count |
| fifo_head | input | 8 | Byte at the receive FIFO head |
| rx_pop | output | 1 | Pop the receive FIFO head |
| fifo_flush | output | 1 | Receive FIFO reset pulse |
| rx_trig | output | 5 | Selected receive trigger level |
| rx_thresh_evt | input | 1 | FIFO reached the trigger level |
| rx_idle_evt | input | 1 | Line idle with data in the FIFO |
| brk_evt | input | 1 | Line break detected |
| txi | output | 1 | Transmit interrupt |
| rxi | output | 1 | Receive interrupt |
| bri | output | 1 | Break interrupt |

## Verification
The bench targets the write-zero-to-clear polarity. A design that cleared on ones, or cleared every flag on any status write, would return the wrong status pattern after partial writes such as 0xFFEF. It checks that the status read returns the flags before the re-arm takes effect. A design that re-armed in the same cycle would return 0x60 where 0x00 is expected. It drives receive reads at fill levels just below and at the trigger, and at zero, which catches an off-by-one in the trigger-clear compare and a pop from an empty FIFO. It also checks that unmapped writes leave the mode register alone, and that the break interrupt stays low while control bit 6 is 0.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

   // register indices and their byte offsets
   localparam int NREG     = 10;
   localparam int RI_MODE  = 0;
   localparam int RI_BRATE = 1;
   localparam int RI_CTRL  = 2;
   localparam int RI_TXD   = 3;
   localparam int RI_STAT  = 4;
   localparam int RI_RXD   = 5;
   localparam int RI_FCTL  = 6;
   localparam int RI_RCNT  = 7;
   localparam int RI_PORT  = 8;
   localparam int RI_LSR   = 9;
   localparam int REG_OFF [NREG] = '{0, 4, 8, 12, 16, 20, 24, 28, 32, 36};

   // write masks
   localparam logic [7:0] MODE_MASK = 8'h7B;
   localparam logic [7:0] CTRL_MASK = 8'hFA;
   localparam logic [7:0] PORT_MASK = 8'hF3;

   // control bit positions
   localparam int CB_TIE = 7;
   localparam int CB_RIE = 6;
   localparam int CB_TE  = 5;

   // status flags and their bit positions in the status word
   localparam int NFLAG   = 5;
   localparam int FI_DR   = 0;
   localparam int FI_RDF  = 1;
   localparam int FI_BRK  = 2;
   localparam int FI_TDE  = 3;
   localparam int FI_TEND = 4;
   localparam int STAT_POS [NFLAG] = '{0, 1, 4, 5, 6};
   localparam logic [NFLAG-1:0] FLAG_RST = 5'b11000;

   // FIFO control fields
   localparam int FC_FLUSH = 1;
   localparam int FC_TRG_LO = 6;

   function automatic int trig_of(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/sercfg_addr_dec.sv
module sercfg_addr_dec
   import sercfg_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [AW-1:0]       bus_addr,
   output logic [NREG-1:0]     wr_sel,
   output logic [NREG-1:0]     rd_sel,
   output logic                rd_miss
);

   logic [NREG-1:0] hit;

   initial begin
      if (AW < 6) $error("sercfg_addr_dec: AW must be at least 6");
   end

   for (genvar g = 0; g < NREG; g++) begin : g_hit
      assign hit[g]    = (bus_addr == AW'(REG_OFF[g]));
      assign wr_sel[g] = bus_en &  bus_we & hit[g];
      assign rd_sel[g] = bus_en & ~bus_we & hit[g];
   end

   assign rd_miss = bus_en & ~bus_we & ~(|hit);

endmodule

// File: rtl/sercfg_flag_cell.sv
module sercfg_flag_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_VAL;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

endmodule

// File: rtl/sercfg_irq_ctl.sv
module sercfg_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic tie_wval,
   input  logic rie_wval,
   input  logic rie_q,
   input  logic rx_ack,
   input  logic rx_raise,
   input  logic brk_q,
   output logic txi,
   output logic rxi,
   output logic bri
);

   logic rx_drop;

   assign rx_drop = rx_ack | (ctrl_wr & ~rie_wval);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txi <= 1'b0;
         rxi <= 1'b0;
      end else begin
         if (ctrl_wr) txi <= tie_wval;
         if (rx_drop)                rxi <= 1'b0;
         else if (rx_raise && rie_q) rxi <= 1'b1;
      end
   end

   assign bri = brk_q & rie_q;

   // R5 / R4: a clearing write always wins on the receive line
   p_rx_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drop |=> !rxi);

endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
   import sercfg_pkg::*;
#(
   parameter  int AW         = 6,
   parameter  int DW         = 16,
   parameter  int FIFO_DEPTH = 16,
   localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_en,
   input  logic             bus_we,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   output logic             tx_valid,
   output logic [7:0]       tx_byte,
   input  logic [CNT_W-1:0] fifo_level,
   input  logic [7:0]       fifo_head,
   output logic             rx_pop,
   output logic             fifo_flush,
   output logic [CNT_W-1:0] rx_trig,
   input  logic             rx_thresh_evt,
   input  logic             rx_idle_evt,
   input  logic             brk_evt,
   output logic             txi,
   output logic             rxi,
   output logic             bri
);

   initial begin
      if (DW < 16)         $error("sercfg_regs: DW must be at least 16");
      if (FIFO_DEPTH < 14) $error("sercfg_regs: FIFO_DEPTH must cover the largest trigger");
   end

   logic [NREG-1:0]  wr_sel, rd_sel;
   logic             rd_miss;
   logic [7:0]       mode_q, brate_q, ctrl_q, port_q;
   logic [DW-1:0]    fctl_q;
   logic [NFLAG-1:0] flag_q, flag_set, flag_clr;
   logic [7:0]       stat_word;
   logic             rearm, pop_drop, rx_ack;

   sercfg_addr_dec #(.AW(AW)) u_dec (
      .bus_en  (bus_en),
      .bus_we  (bus_we),
      .bus_addr(bus_addr),
      .wr_sel  (wr_sel),
      .rd_sel  (rd_sel),
      .rd_miss (rd_miss)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 8'h00;
         brate_q <= 8'hFF;
         ctrl_q  <= 8'h20;
         port_q  <= 8'h00;
         fctl_q  <= '0;
      end else begin
         if (wr_sel[RI_MODE])  mode_q  <= bus_wdata[7:0] & MODE_MASK;
         if (wr_sel[RI_BRATE]) brate_q <= bus_wdata[7:0];
         if (wr_sel[RI_CTRL])  ctrl_q  <= bus_wdata[7:0] & CTRL_MASK;
         if (wr_sel[RI_PORT])  port_q  <= bus_wdata[7:0] & PORT_MASK;
         if (wr_sel[RI_FCTL])  fctl_q  <= bus_wdata;
      end
   end

   // transmit strobe and flush pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid   <= 1'b0;
         tx_byte    <= 8'h00;
         fifo_flush <= 1'b0;
      end else begin
         tx_valid   <= wr_sel[RI_TXD];
         fifo_flush <= wr_sel[RI_FCTL] & bus_wdata[FC_FLUSH];
         if (wr_sel[RI_TXD]) tx_byte <= bus_wdata[7:0];
      end
   end

   assign rx_trig  = CNT_W'(trig_of(fctl_q[FC_TRG_LO +: 2]));
   assign rx_pop   = rd_sel[RI_RXD] & (fifo_level != '0);
   assign pop_drop = rx_pop & ((fifo_level - CNT_W'(1)) < rx_trig);
   assign rearm    = rd_sel[RI_STAT] & ctrl_q[CB_TE];

   // set / clear sources for each status flag
   always_comb begin
      flag_set = '0;
      flag_clr = '0;
      for (int i = 0; i < NFLAG; i++)
         flag_clr[i] = wr_sel[RI_STAT] & ~bus_wdata[STAT_POS[i]];
      flag_set[FI_TEND] = rearm | (wr_sel[RI_CTRL] & ~bus_wdata[CB_TE]);
      flag_set[FI_TDE]  = rearm;
      flag_clr[FI_TDE]  = flag_clr[FI_TDE] | wr_sel[RI_TXD];
      flag_set[FI_BRK]  = brk_evt;
      flag_set[FI_RDF]  = rx_thresh_evt;
      flag_clr[FI_RDF]  = flag_clr[FI_RDF] | pop_drop
                        | (wr_sel[RI_FCTL] & bus_wdata[FC_FLUSH]);
      flag_set[FI_DR]   = rx_idle_evt;
   end

   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      sercfg_flag_cell #(.RST_VAL(FLAG_RST[f])) u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (flag_set[f]),
         .clr  (flag_clr[f]),
         .q    (flag_q[f])
      );
   end

   always_comb begin
      stat_word = 8'h00;
      for (int i = 0; i < NFLAG; i++) stat_word[STAT_POS[i]] = flag_q[i];
   end

   assign rx_ack = wr_sel[RI_STAT] & ~(bus_wdata[STAT_POS[FI_RDF]] & bus_wdata[STAT_POS[FI_DR]]);

   sercfg_irq_ctl u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (wr_sel[RI_CTRL]),
      .tie_wval(bus_wdata[CB_TIE]),
      .rie_wval(bus_wdata[CB_RIE]),
      .rie_q   (ctrl_q[CB_RIE]),
      .rx_ack  (rx_ack),
      .rx_raise(rx_thresh_evt | rx_idle_evt),
      .brk_q   (flag_q[FI_BRK]),
      .txi     (txi),
      .rxi     (rxi),
      .bri     (bri)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (rd_sel[RI_MODE])  bus_rdata = DW'(mode_q);
      if (rd_sel[RI_BRATE]) bus_rdata = DW'(brate_q);
      if (rd_sel[RI_CTRL])  bus_rdata = DW'(ctrl_q);
      if (rd_sel[RI_STAT])  bus_rdata = DW'(stat_word);
      if (rx_pop)           bus_rdata = DW'(fifo_head);
      if (rd_sel[RI_FCTL])  bus_rdata = fctl_q;
      if (rd_sel[RI_RCNT])  bus_rdata = DW'(fifo_level);
      if (rd_sel[RI_PORT])  bus_rdata = DW'(port_q);
   end

   // assertions
   p_tx_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[RI_TXD] |=> tx_valid && !flag_q[FI_TDE] && tx_byte == $past(bus_wdata[7:0]));

   p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> flag_q[FI_TEND] && flag_q[FI_TDE]);

   p_txi_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[RI_CTRL] |=> txi == $past(bus_wdata[CB_TIE]));

   p_flush_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[RI_FCTL] && bus_wdata[FC_FLUSH]) |=> fifo_flush && !flag_q[FI_RDF] || $past(rx_thresh_evt));

   p_brk_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> flag_q[FI_BRK]);

   p_no_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level == '0 |-> !rx_pop);

   always_ff @(posedge clk) begin
      if (rst_n && rd_miss)
         p_unmapped_zero_r9: assert (bus_rdata == '0);
   end

endmodule

// File: tb/sercfg_regs_test.sv
module sercfg_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        tx_valid;
   logic [7:0]  tx_byte;
   logic [4:0]  fifo_level = '0;
   logic [7:0]  fifo_head = '0;
   logic        rx_pop, fifo_flush;
   logic [4:0]  rx_trig;
   logic        rx_thresh_evt = 1'b0, rx_idle_evt = 1'b0, brk_evt = 1'b0;
   logic        txi, rxi, bri;

   int vectors = 0;
   int miscompares = 0;
   logic last_pop;

   always #4 clk = ~clk;

   sercfg_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .fifo_level(fifo_level),
      .fifo_head(fifo_head), .rx_pop(rx_pop), .fifo_flush(fifo_flush),
      .rx_trig(rx_trig), .rx_thresh_evt(rx_thresh_evt), .rx_idle_evt(rx_idle_evt),
      .brk_evt(brk_evt), .txi(txi), .rxi(rxi), .bri(bri)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      last_pop = rx_pop;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic pulse_thresh();
      @(negedge clk); rx_thresh_evt = 1'b1; @(negedge clk); rx_thresh_evt = 1'b0;
   endtask
   task automatic pulse_idle();
      @(negedge clk); rx_idle_evt = 1'b1; @(negedge clk); rx_idle_evt = 1'b0;
   endtask
   task automatic pulse_brk();
      @(negedge clk); brk_evt = 1'b1; @(negedge clk); brk_evt = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      rd(6'h00, d); check("R1 mode", d, 16'h0000);
      rd(6'h04, d); check("R1 bit rate", d, 16'h00FF);
      rd(6'h08, d); check("R1 control", d, 16'h0020);
      rd(6'h20, d); check("R1 port", d, 16'h0000);
      rd(6'h18, d); check("R1 fifo ctrl", d, 16'h0000);
      rd(6'h10, d); check("R1 status", d, 16'h0060);
      check("R1 irq lines", {13'd0, txi, rxi, bri}, 16'h0000);
      check("R1 trigger", 16'(rx_trig), 16'd1);
   endtask

   task automatic t_masks();
      logic [15:0] d;
      wr(6'h00, 16'hFFFF); rd(6'h00, d); check("R2 mode mask", d, 16'h007B);
      wr(6'h08, 16'hFFFF); rd(6'h08, d); check("R2 control mask", d, 16'h00FA);
      wr(6'h20, 16'hFFFF); rd(6'h20, d); check("R2 port mask", d, 16'h00F3);
      wr(6'h04, 16'h1234); rd(6'h04, d); check("R2 bit rate", d, 16'h0034);
   endtask

   task automatic t_status_clear();
      logic [15:0] d;
      wr(6'h08, 16'h0000);
      wr(6'h10, 16'h0000);
      pulse_brk(); pulse_thresh(); pulse_idle();
      rd(6'h10, d); check("R3 flags set", d, 16'h0013);
      wr(6'h08, 16'h0000);
      rd(6'h10, d); check("R5 te clear sets tend", d, 16'h0053);
      wr(6'h10, 16'hFFEF); rd(6'h10, d); check("R3 clear break only", d, 16'h0043);
      wr(6'h10, 16'hFFFE); rd(6'h10, d); check("R3 clear ready only", d, 16'h0042);
      wr(6'h10, 16'hFFBF); rd(6'h10, d); check("R3 clear tend only", d, 16'h0002);
   endtask

   task automatic t_rx_irq();
      logic [15:0] d;
      wr(6'h08, 16'h0040);
      wr(6'h10, 16'h0000);
      pulse_thresh(); check("R11 trigger raises rxi", 16'(rxi), 16'd1);
      wr(6'h10, 16'hFFFE); check("R4 status zero drops rxi", 16'(rxi), 16'd0);
      pulse_idle(); check("R11 idle raises rxi", 16'(rxi), 16'd1);
      wr(6'h08, 16'h0000); check("R5 rie off drops rxi", 16'(rxi), 16'd0);
      pulse_thresh(); check("R11 masked trigger", 16'(rxi), 16'd0);
      rd(6'h10, d); check("R11 flag without irq", d & 16'h0003, 16'h0003);
   endtask

   task automatic t_tx();
      wr(6'h08, 16'h0000);
      wr(6'h0C, 16'h01A5);
      check("R6 strobe", 16'(tx_valid), 16'd1);
      check("R6 byte", 16'(tx_byte), 16'h00A5);
      @(negedge clk); check("R6 single pulse", 16'(tx_valid), 16'd0);
      wr(6'h08, 16'h0080); check("R5 txi high", 16'(txi), 16'd1);
      wr(6'h08, 16'h0000); check("R5 txi low", 16'(txi), 16'd0);
   endtask

   task automatic t_rearm();
      logic [15:0] d;
      wr(6'h08, 16'h0020);
      wr(6'h10, 16'h0000);
      rd(6'h10, d); check("R7 value before rearm", d, 16'h0000);
      rd(6'h10, d); check("R7 rearmed", d, 16'h0060);
      wr(6'h0C, 16'h0033);
      rd(6'h10, d); check("R6 tde cleared", d, 16'h0040);
      rd(6'h10, d); check("R7 rearm after tx", d, 16'h0060);
      rd(6'h0C, d); check("R6 tx data reads zero", d, 16'h0000);
      wr(6'h08, 16'h0000);
      wr(6'h10, 16'h0000);
      rd(6'h10, d); rd(6'h10, d); check("R7 no rearm with te off", d, 16'h0000);
   endtask

   task automatic t_fifo_ctrl();
      logic [15:0] d;
      pulse_thresh();
      wr(6'h18, 16'h00C2);
      check("R8 flush pulse", 16'(fifo_flush), 16'd1);
      check("R8 trigger 14", 16'(rx_trig), 16'd14);
      rd(6'h18, d); check("R8 readback", d, 16'h00C2);
      rd(6'h10, d); check("R8 flush clears rdf", d & 16'h0002, 16'h0000);
      wr(6'h18, 16'h0040); check("R8 trigger 4", 16'(rx_trig), 16'd4);
      check("R8 no flush", 16'(fifo_flush), 16'd0);
      wr(6'h18, 16'h0080); check("R8 trigger 8", 16'(rx_trig), 16'd8);
      wr(6'h18, 16'h0000); check("R8 trigger 1", 16'(rx_trig), 16'd1);
   endtask

   task automatic t_counts_unmapped();
      logic [15:0] d;
      fifo_level = 5'd7;
      rd(6'h1C, d); check("R9 fill count", d, 16'h0007);
      rd(6'h24, d); check("R9 line status", d, 16'h0000);
      wr(6'h00, 16'h0011);
      wr(6'h28, 16'hFFFF);
      wr(6'h3C, 16'hFFFF);
      rd(6'h28, d); check("R9 unmapped read", d, 16'h0000);
      rd(6'h00, d); check("R9 unmapped write ignored", d, 16'h0011);
      fifo_level = 5'd0;
   endtask

   task automatic t_rx_read();
      logic [15:0] d;
      wr(6'h18, 16'h0040);
      wr(6'h08, 16'h0000);
      wr(6'h10, 16'h0000);
      pulse_thresh();
      fifo_level = 5'd3; fifo_head = 8'h5A;
      rd(6'h14, d); check("R10 head byte", d, 16'h005A);
      check("R10 pop", 16'(last_pop), 16'd1);
      rd(6'h10, d); check("R10 below trigger clears", d & 16'h0002, 16'h0000);
      pulse_thresh();
      fifo_level = 5'd5;
      rd(6'h14, d);
      rd(6'h10, d); check("R10 at trigger keeps", d & 16'h0002, 16'h0002);
      fifo_level = 5'd0;
      rd(6'h14, d); check("R10 empty reads zero", d, 16'h0000);
      check("R10 empty no pop", 16'(last_pop), 16'd0);
   endtask

   task automatic t_break();
      wr(6'h08, 16'h0040);
      wr(6'h10, 16'h0000);
      pulse_brk(); check("R12 bri raised", 16'(bri), 16'd1);
      wr(6'h10, 16'hFFEF); check("R12 bri cleared", 16'(bri), 16'd0);
      wr(6'h08, 16'h0000);
      pulse_brk(); check("R12 bri gated by rie", 16'(bri), 16'd0);
   endtask

   initial begin
      #200us;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_masks();
      t_status_clear();
      t_rx_irq();
      t_tx();
      t_rearm();
      t_fifo_ctrl();
      t_counts_unmapped();
      t_rx_read();
      t_break();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule